// File: doc/BRIEF.md
# Banked GPIO Controller with Pin Interrupts

This block is a register-mapped general-purpose I/O controller for 32 pins, split into four banks of eight. Each bank has its own 64-byte window on a simple synchronous register bus. Software uses the window to set pin direction and output data, read the sampled pin levels, and handle per-pin interrupts. The interrupt side has a raw status, a mask, a masked view and a per-pin choice between edge and level latching.

Pin inputs pass through a two-flop synchronizer before any read or interrupt logic sees them. A pin in edge mode latches its status bit on a rising edge of its synchronized level. A pin in level ("sticky") mode keeps its status bit set for as long as the level stays high, so a clear written during that time has no lasting effect. One interrupt line is the OR of all masked status bits across the banks.

Bus reads are combinational from the address. A write takes effect at the clock edge where the write enable is high. Pin n belongs to bank n/8 at bit n%8. Address bits [7:6] select the bank and bits [5:0] select the register inside the window.

Top module: `pinbank_gpio`

## Requirements
- R1: After reset every direction and mask bit is 1 and every output, status and sticky bit is 0, so pin_oe, pin_out and irq are all 0.
- R2: Pin n is controlled through bank n/8 (address bits [7:6]) at data bit n%8. Output data written at window offset 0x14 drives pin_out and reads back from the same offset.
- R3: The direction register at window offset 0x10 reads back as written; a 1 makes the pin an input, and pin_oe for that pin is the inverse of its direction bit.
- R4: Window offset 0x18 returns the pin levels delayed by two clock edges: a change on pin_in is not visible after one edge and is visible after the second.
- R5: For a pin whose sticky bit is 0, a rising edge of the synchronized input sets its raw status bit (window offset 0x04) one edge after the synchronized level rises. A level that stays high does not set the bit again after it is cleared.
- R6: Writing window offset 0x04 clears the raw status bits written as 1 and leaves the bits written as 0 unchanged.
- R7: Writing 1s to window offset 0x08 sets those mask bits, and writing 1s to offset 0x0C clears them. Offset 0x08 reads the mask, offset 0x0C reads zero, and irq stays 0 while every mask bit is set.
- R8: Window offset 0x00 reads raw status AND NOT mask. irq is 1 exactly when any bank has a bit set in that masked view.
- R9: Writing 1s to window offset 0x20 sets sticky bits, and writing 0s leaves them set. For a sticky pin the status bit stays set while the synchronized level is high, even across a clear write, and a clear takes effect once the level is low.
- R10: Writes to read-only offsets (0x00, 0x18) and to unmapped offsets change no state. Unmapped offsets read zero, and data bits above bit 7 always read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 8 | Byte address: bank in [7:6], register in [5:0] |
| bus_we | input | 1 | Write enable, sampled at the rising clock edge |
| bus_wdata | input | 16 | Write data; only bits [7:0] are used |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| pin_in | input | 32 | Asynchronous pin levels |
| pin_out | output | 32 | Output data for each pin |
| pin_oe | output | 32 | Output enable for each pin, 1 = drive |
| irq | output | 1 | Combined masked interrupt |

## Verification
The bench measures the synchronizer delay one edge at a time. A design with one flop too few or too many shows the new level on the wrong read. It holds an edge-mode pin high across a status clear, where a design that latched on level would raise the bit again. It does the same on a sticky pin, where a design that let the clear win would drop irq while the level is still present. It also writes ones to the read-only, unmapped and write-only offsets and to the upper data bits. A decoder with overlapping offsets, or a mask port that also reads back, would then corrupt neighbouring registers or return non-zero data.

// File: rtl/pinbank_pkg.sv
// Shared constants for the banked GPIO controller.
// Assumes a 64-byte window per bank; register offsets are byte addresses.
package pinbank_pkg;
    localparam int WIN_BITS = 6;

    localparam logic [WIN_BITS-1:0] REG_MSTAT  = 6'h00;
    localparam logic [WIN_BITS-1:0] REG_STAT   = 6'h04;
    localparam logic [WIN_BITS-1:0] REG_MSET   = 6'h08;
    localparam logic [WIN_BITS-1:0] REG_MCLR   = 6'h0C;
    localparam logic [WIN_BITS-1:0] REG_DIR    = 6'h10;
    localparam logic [WIN_BITS-1:0] REG_OUT    = 6'h14;
    localparam logic [WIN_BITS-1:0] REG_IN     = 6'h18;
    localparam logic [WIN_BITS-1:0] REG_STICKY = 6'h20;
endpackage

// File: rtl/pinbank_sync.sv
// Two-flop synchronizer for the pin inputs, plus one more stage that
// holds the previous synchronized value for edge detection.
// Assumes pin_in is asynchronous; each bit is treated on its own.
module pinbank_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out,
    output logic [W-1:0] sync_prev
);
    logic [W-1:0] meta_q;

    // Shift the pin levels through the synchronizer and the history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q    <= '0;
            sync_out  <= '0;
            sync_prev <= '0;
        end else begin
            meta_q    <= async_in;
            sync_out  <= meta_q;
            sync_prev <= sync_out;
        end
    end
endmodule

// File: rtl/pinbank_bank.sv
// One bank of the GPIO controller: direction, output data, mask, sticky
// and status registers for W pins, its register read mux and the bank's
// masked interrupt term.
// Assumes the caller decodes bank selection and passes the window offset.
module pinbank_bank
    import pinbank_pkg::*;
#(
    parameter int W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sel,
    input  logic                we,
    input  logic [WIN_BITS-1:0] offs,
    input  logic [W-1:0]        wdata,
    input  logic [W-1:0]        sync_in,
    input  logic [W-1:0]        prev_in,
    output logic [W-1:0]        rdata,
    output logic [W-1:0]        out_q,
    output logic [W-1:0]        dir_q,
    output logic [W-1:0]        stat_q,
    output logic [W-1:0]        mask_q,
    output logic [W-1:0]        sticky_q,
    output logic                irq_any
);
    logic         wr;
    logic [W-1:0] clr_bits;
    logic [W-1:0] set_bits;

    assign wr = sel && we;

    // Status bits to clear this cycle from a write to the status offset.
    assign clr_bits = (wr && offs == REG_STAT) ? wdata : '0;

    // Status bits to set: level for sticky pins, rising edge otherwise.
    assign set_bits = (sticky_q & sync_in) | (~sticky_q & sync_in & ~prev_in);

    // Direction and output data registers, written directly.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= '1;
            out_q <= '0;
        end else if (wr) begin
            if (offs == REG_DIR) dir_q <= wdata;
            if (offs == REG_OUT) out_q <= wdata;
        end
    end

    // Mask register with separate set and clear write ports.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '1;
        end else if (wr) begin
            if (offs == REG_MSET) mask_q <= mask_q | wdata;
            if (offs == REG_MCLR) mask_q <= mask_q & ~wdata;
        end
    end

    // Sticky selector, set-only from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) sticky_q <= '0;
        else if (wr && offs == REG_STICKY) sticky_q <= sticky_q | wdata;
    end

    // Raw status: clear first, then a new set wins in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~clr_bits) | set_bits;
    end

    // Register read mux for this bank's window.
    always_comb begin
        case (offs)
            REG_MSTAT:  rdata = stat_q & ~mask_q;
            REG_STAT:   rdata = stat_q;
            REG_MSET:   rdata = mask_q;
            REG_DIR:    rdata = dir_q;
            REG_OUT:    rdata = out_q;
            REG_IN:     rdata = sync_in;
            REG_STICKY: rdata = sticky_q;
            default:    rdata = '0;
        endcase
    end

    // The bank's contribution to the combined interrupt.
    assign irq_any = |(stat_q & ~mask_q);
endmodule

// File: rtl/pinbank_gpio.sv
// Top level of the banked GPIO controller: synchronizes the pins, decodes
// the bank from the address, instantiates one register bank per group of
// pins and merges read data and interrupts.
// Assumes ADDR_W equals WIN_BITS plus the bank index width.
module pinbank_gpio
    import pinbank_pkg::*;
#(
    parameter int N_BANKS = 4,
    parameter int BANK_W  = 8,
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic                      bus_we,
    input  logic [DATA_W-1:0]         bus_wdata,
    output logic [DATA_W-1:0]         bus_rdata,
    input  logic [N_BANKS*BANK_W-1:0] pin_in,
    output logic [N_BANKS*BANK_W-1:0] pin_out,
    output logic [N_BANKS*BANK_W-1:0] pin_oe,
    output logic                      irq
);
    localparam int NPINS  = N_BANKS * BANK_W;
    localparam int BIDX_W = ADDR_W - WIN_BITS;

    logic [NPINS-1:0]        sync_v;
    logic [NPINS-1:0]        prev_v;
    logic [NPINS-1:0]        stat_v;
    logic [NPINS-1:0]        mask_v;
    logic [NPINS-1:0]        sticky_v;
    logic [NPINS-1:0]        dir_v;
    logic [BANK_W-1:0]       bank_rd [N_BANKS];
    logic [N_BANKS-1:0]      bank_irq;
    logic [N_BANKS-1:0]      bank_sel;
    logic [BIDX_W-1:0]       bank_idx;
    logic [WIN_BITS-1:0]     offs;
    logic                    unused_hi;

    assign bank_idx  = bus_addr[ADDR_W-1:WIN_BITS];
    assign offs      = bus_addr[WIN_BITS-1:0];
    assign unused_hi = ^bus_wdata[DATA_W-1:BANK_W];

    pinbank_sync #(.W(NPINS)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .async_in  (pin_in),
        .sync_out  (sync_v),
        .sync_prev (prev_v)
    );

    for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
        localparam int LO = b * BANK_W;

        // One-hot bank select from the address.
        assign bank_sel[b] = (bank_idx == BIDX_W'(b));

        pinbank_bank #(.W(BANK_W)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .sel      (bank_sel[b]),
            .we       (bus_we),
            .offs     (offs),
            .wdata    (bus_wdata[BANK_W-1:0]),
            .sync_in  (sync_v[LO +: BANK_W]),
            .prev_in  (prev_v[LO +: BANK_W]),
            .rdata    (bank_rd[b]),
            .out_q    (pin_out[LO +: BANK_W]),
            .dir_q    (dir_v[LO +: BANK_W]),
            .stat_q   (stat_v[LO +: BANK_W]),
            .mask_q   (mask_v[LO +: BANK_W]),
            .sticky_q (sticky_v[LO +: BANK_W]),
            .irq_any  (bank_irq[b])
        );
    end

    // Output enable is active for pins configured as outputs.
    assign pin_oe = ~dir_v;

    // Merge the selected bank's read data, zero-extended to the bus width.
    always_comb begin
        bus_rdata = '0;
        for (int b = 0; b < N_BANKS; b++) begin
            if (bank_sel[b]) bus_rdata[BANK_W-1:0] = bank_rd[b];
        end
    end

    // Combined interrupt from all banks.
    assign irq = |bank_irq;
endmodule

// File: rtl/pinbank_gpio_chk.sv
// Assertion checker for pinbank_gpio, attached by bind. It observes the
// synchronized pins and the interrupt state registers of all banks.
module pinbank_gpio_chk #(
    parameter int NPINS = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NPINS-1:0] pin_oe,
    input logic             irq,
    input logic [NPINS-1:0] sync_v,
    input logic [NPINS-1:0] prev_v,
    input logic [NPINS-1:0] stat_v,
    input logic [NPINS-1:0] mask_v,
    input logic [NPINS-1:0] sticky_v
);
    logic [NPINS-1:0] edge_c;
    logic [NPINS-1:0] lvl_c;

    assign edge_c = sync_v & ~prev_v & ~sticky_v;
    assign lvl_c  = sync_v & sticky_v;

    // R1: right after reset no pin is driven and no interrupt is raised.
    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pin_oe == '0 && !irq));

    // R5: a synchronized rising edge on an edge-mode pin sets its status.
    a_r5_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_c != '0) |=> ((stat_v & $past(edge_c)) == $past(edge_c)));

    // R9: a high level on a sticky pin keeps its status set.
    a_r9_level_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_c != '0) |=> ((stat_v & $past(lvl_c)) == $past(lvl_c)));

    // R7: with every pin masked, the interrupt output stays low.
    a_r7_all_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask_v) |-> !irq);
endmodule

bind pinbank_gpio pinbank_gpio_chk #(.NPINS(NPINS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_oe   (pin_oe),
    .irq      (irq),
    .sync_v   (sync_v),
    .prev_v   (prev_v),
    .stat_v   (stat_v),
    .mask_v   (mask_v),
    .sticky_v (sticky_v)
);

// File: tb/pinbank_gpio_bench.sv
// Directed bench for pinbank_gpio: one task per scenario, each checking
// its own results against values derived from the requirements.
module pinbank_gpio_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out;
    logic [31:0] pin_oe;
    logic        irq;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    pinbank_gpio u_pinbank_gpio (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .irq       (irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [7:0] a, input logic [15:0] exp);
        @(negedge clk);
        bus_addr = a;
        bus_we   = 1'b0;
        #1;
        check(req, {16'h0, bus_rdata}, {16'h0, exp});
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        for (int b = 0; b < 4; b++) begin
            rd_check("R1 dir", 8'(b * 64 + 8'h10), 16'h00FF);
            rd_check("R1 mask", 8'(b * 64 + 8'h08), 16'h00FF);
            rd_check("R1 stat", 8'(b * 64 + 8'h04), 16'h0000);
            rd_check("R1 sticky", 8'(b * 64 + 8'h20), 16'h0000);
            rd_check("R1 out", 8'(b * 64 + 8'h14), 16'h0000);
        end
        check("R1 pin_oe", pin_oe, 32'h0);
        check("R1 pin_out", pin_out, 32'h0);
        check("R1 irq", {31'h0, irq}, 32'h0);
    endtask

    task automatic t_direction_output;
        wr(8'h50, 16'h000F);
        wr(8'h54, 16'hFFA5);
        rd_check("R3 dir readback", 8'h50, 16'h000F);
        rd_check("R10 upper bits zero", 8'h54, 16'h00A5);
        check("R3 pin_oe inverse", pin_oe, 32'h0000F000);
        check("R2 pin_out bank1", pin_out, 32'h0000A500);
    endtask

    task automatic t_sync_delay;
        @(negedge clk);
        pin_in[5] = 1'b1;
        bus_addr  = 8'h18;
        #1;
        check("R4 before edge", {16'h0, bus_rdata}, 32'h0);
        rd_check("R4 after one edge", 8'h18, 16'h0000);
        rd_check("R4 after two edges", 8'h18, 16'h0020);
        @(negedge clk);
        pin_in[5] = 1'b0;
        idle(3);
    endtask

    task automatic t_edge_irq;
        @(negedge clk);
        pin_in[10] = 1'b1;
        idle(4);
        rd_check("R5 edge sets status", 8'h44, 16'h0004);
        rd_check("R8 masked view hidden", 8'h40, 16'h0000);
        check("R7 masked no irq", {31'h0, irq}, 32'h0);
        wr(8'h4C, 16'h0004);
        rd_check("R7 mask clear", 8'h48, 16'h00FB);
        rd_check("R7 clear port reads zero", 8'h4C, 16'h0000);
        rd_check("R8 masked view", 8'h40, 16'h0004);
        check("R8 irq raised", {31'h0, irq}, 32'h1);
        wr(8'h44, 16'h0004);
        idle(2);
        rd_check("R5 no retrigger while high", 8'h44, 16'h0000);
        check("R6 irq after clear", {31'h0, irq}, 32'h0);
        @(negedge clk);
        pin_in[10] = 1'b0;
        idle(3);
        pin_in[10] = 1'b1;
        idle(4);
        wr(8'h44, 16'h00FB);
        rd_check("R6 zero bits keep status", 8'h44, 16'h0004);
        wr(8'h44, 16'h0004);
        rd_check("R6 one bit clears", 8'h44, 16'h0000);
        wr(8'h48, 16'h0004);
        rd_check("R7 mask set", 8'h48, 16'h00FF);
        @(negedge clk);
        pin_in[10] = 1'b0;
        idle(3);
    endtask

    task automatic t_sticky;
        wr(8'hE0, 16'h0008);
        rd_check("R9 sticky set", 8'hE0, 16'h0008);
        wr(8'hE0, 16'h0000);
        rd_check("R9 zeros keep sticky", 8'hE0, 16'h0008);
        wr(8'hCC, 16'h0008);
        @(negedge clk);
        pin_in[27] = 1'b1;
        idle(4);
        rd_check("R9 level sets status", 8'hC4, 16'h0008);
        wr(8'hC4, 16'h0008);
        rd_check("R9 clear overridden", 8'hC4, 16'h0008);
        check("R9 irq held", {31'h0, irq}, 32'h1);
        @(negedge clk);
        pin_in[27] = 1'b0;
        idle(3);
        wr(8'hC4, 16'h0008);
        rd_check("R9 clear after low", 8'hC4, 16'h0000);
        check("R9 irq dropped", {31'h0, irq}, 32'h0);
    endtask

    task automatic t_readonly_and_combine;
        wr(8'h58, 16'hFFFF);
        wr(8'h40, 16'hFFFF);
        wr(8'h5C, 16'hFFFF);
        wr(8'h7C, 16'hFFFF);
        rd_check("R10 input reg unchanged", 8'h58, 16'h0000);
        rd_check("R10 unmapped reads zero", 8'h5C, 16'h0000);
        rd_check("R10 status unchanged", 8'h44, 16'h0000);
        rd_check("R10 mask unchanged", 8'h48, 16'h00FF);
        rd_check("R10 dir unchanged", 8'h50, 16'h000F);
        rd_check("R10 out unchanged", 8'h54, 16'h00A5);
        rd_check("R5 bank0 pin5 latched", 8'h04, 16'h0020);
        wr(8'h0C, 16'h0020);
        rd_check("R8 bank0 masked view", 8'h00, 16'h0020);
        check("R8 irq from bank0", {31'h0, irq}, 32'h1);
        wr(8'h04, 16'h0020);
        check("R8 irq cleared", {31'h0, irq}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_direction_output();
        t_sync_delay();
        t_edge_irq();
        t_sticky();
        t_readonly_and_combine();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end
endmodule